// File: doc/BRIEF.md
# Display Refresh Line Pointer

This block produces the display-memory line address used while a passive LCD panel is refreshed. Software sets a start-line register through a one-cycle write strobe. That register names the memory line shown on the first common row of the panel. The refresh timing supplies two slow, asynchronous signals: a frame toggle and a line clock.

Both signals pass through a synchroniser and an edge detector, so each becomes a single-cycle strobe in the system clock domain. Every transition of the frame toggle, rising or falling, copies the start line into the line pointer. Every active edge of the line clock advances the pointer by one line, and the pointer wraps from the last line back to zero. Because the start line can be programmed, the picture scrolls vertically with no data moved in memory. A new start line only shows at the next frame transition.

Top module: `lcd_line_scan`

## Requirements
- R1: While `rst_n` is low and after its release, `line_ptr` reads 0 and the stored start line is 0, until a frame transition or line clock edge is seen.
- R2: A high `start_wr` at a rising `clk` edge stores `start_data` as the start line. A write alone never changes `line_ptr`.
- R3: A rising transition of `fr_in` loads the stored start line into `line_ptr`. If `fr_in` is first sampled high at `clk` edge k, `line_ptr` shows the value from edge k+SYNC_STAGES.
- R4: A falling transition of `fr_in` performs the same reload as R3, with the same latency.
- R5: Each active edge of `cl_in` advances `line_ptr` by exactly one, with the latency of R3. The active edge is rising when CL_ON_RISE=1 (the default), and the other edge of `cl_in` has no effect.
- R6: An advance from line LINES-1 (31 by default) gives line 0.
- R7: If a frame transition and a line clock edge reach the counter in the same cycle, the reload wins and `line_ptr` takes the start line.
- R8: In a cycle with neither strobe, `line_ptr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Start-line write strobe |
| start_data | input | LW (5) | Start line to store |
| fr_in | input | 1 | Asynchronous frame toggle |
| cl_in | input | 1 | Asynchronous line clock |
| line_ptr | output | LW (5) | Memory line being refreshed |

## Verification
The bound checker watches the internal strobes on every cycle. It checks that a frame strobe reloads the pointer from the stored start line, that a lone line strobe adds one and wraps at the top, and that the pointer holds when no strobe is present. It also checks that the register takes written data and keeps it otherwise, and that a line strobe never lasts two cycles. Only the bench can show the behaviour at the pins: the synchroniser latency, that both polarities of the frame toggle reload, that the inactive line clock edge does nothing, and that a start-line write waits for the next frame.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2
   } edge_kind_e;
endpackage

// File: rtl/scan_sync_edge.sv
// Synchronises an asynchronous level and produces a one-cycle strobe on the
// selected transition(s).
module scan_sync_edge #(
   parameter int                      STAGES = 2,
   parameter lcd_scan_pkg::edge_kind_e KIND  = lcd_scan_pkg::EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic strobe
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;
   logic              cur;

   if (STAGES < 2) begin : g_bad_stages
      $error("scan_sync_edge: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_in};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign cur = sync_q[STAGES-1];

   if (KIND == lcd_scan_pkg::EDGE_RISE) begin : g_rise
      assign strobe = cur & ~last_q;
   end else if (KIND == lcd_scan_pkg::EDGE_FALL) begin : g_fall
      assign strobe = ~cur & last_q;
   end else begin : g_both
      assign strobe = cur ^ last_q;
   end
endmodule

// File: rtl/scan_start_reg.sv
// Holds the programmed first display line.
module scan_start_reg #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] value_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     value_q <= '0;
      else if (wr_en) value_q <= wr_data;
   end
endmodule

// File: rtl/scan_line_counter.sv
// Reloadable line counter; reload has priority over advance.
module scan_line_counter #(
   parameter int LINES = 32,
   parameter int W     = $clog2(LINES)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reload,
   input  logic         advance,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count_q
);
   localparam logic [W-1:0] TOP = W'(LINES - 1);

   logic [W-1:0] stepped;

   always_comb begin
      if (count_q == TOP) stepped = '0;
      else                stepped = count_q + W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       count_q <= '0;
      else if (reload)  count_q <= load_val;
      else if (advance) count_q <= stepped;
   end
endmodule

// File: rtl/lcd_line_scan.sv
module lcd_line_scan #(
   parameter  int LINES       = 32,
   parameter  int SYNC_STAGES = 2,
   parameter  bit CL_ON_RISE  = 1'b1,
   localparam int LW          = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_wr,
   input  logic [LW-1:0] start_data,
   input  logic          fr_in,
   input  logic          cl_in,
   output logic [LW-1:0] line_ptr
);
   import lcd_scan_pkg::*;

   localparam edge_kind_e CL_KIND = CL_ON_RISE ? EDGE_RISE : EDGE_FALL;

   if (LINES < 2 || (1 << LW) != LINES) begin : g_bad_lines
      $error("lcd_line_scan: LINES must be a power of two, at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lcd_line_scan: SYNC_STAGES must be at least 2");
   end

   logic          fr_stb;
   logic          cl_stb;
   logic [LW-1:0] start_q;

   scan_sync_edge #(.STAGES(SYNC_STAGES), .KIND(EDGE_BOTH)) u_fr_edge (
      .clk(clk), .rst_n(rst_n), .async_in(fr_in), .strobe(fr_stb)
   );

   scan_sync_edge #(.STAGES(SYNC_STAGES), .KIND(CL_KIND)) u_cl_edge (
      .clk(clk), .rst_n(rst_n), .async_in(cl_in), .strobe(cl_stb)
   );

   scan_start_reg #(.W(LW)) u_start (
      .clk(clk), .rst_n(rst_n), .wr_en(start_wr), .wr_data(start_data),
      .value_q(start_q)
   );

   scan_line_counter #(.LINES(LINES), .W(LW)) u_count (
      .clk(clk), .rst_n(rst_n), .reload(fr_stb), .advance(cl_stb),
      .load_val(start_q), .count_q(line_ptr)
   );
endmodule

// File: rtl/lcd_line_scan_chk.sv
module lcd_line_scan_chk #(
   parameter int LINES = 32,
   parameter int LW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_wr,
   input logic [LW-1:0] start_data,
   input logic          fr_stb,
   input logic          cl_stb,
   input logic [LW-1:0] start_q,
   input logic [LW-1:0] line_ptr
);
   localparam logic [LW-1:0] TOP = LW'(LINES - 1);

   assert_reload_R3_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fr_stb |=> line_ptr == $past(start_q));

   assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!fr_stb && cl_stb && line_ptr != TOP) |=> line_ptr == $past(line_ptr) + LW'(1));

   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!fr_stb && cl_stb && line_ptr == TOP) |=> line_ptr == '0);

   assert_single_line_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cl_stb |=> !cl_stb);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!fr_stb && !cl_stb) |=> $stable(line_ptr));

   assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> start_q == $past(start_data));

   assert_start_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !start_wr |=> $stable(start_q));
endmodule

bind lcd_line_scan lcd_line_scan_chk #(.LINES(LINES), .LW(LW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_data(start_data),
   .fr_stb(fr_stb), .cl_stb(cl_stb), .start_q(start_q), .line_ptr(line_ptr)
);

// File: tb/lcd_line_scan_tb.sv
`timescale 1ns/1ps
module lcd_line_scan_tb;
   localparam int LINES = 32;
   localparam int SYNC  = 2;
   localparam int LW    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_wr = 1'b0;
   logic [LW-1:0] start_data = '0;
   logic          fr_in = 1'b0;
   logic          cl_in = 1'b0;
   logic [LW-1:0] line_ptr;

   int    n_checks = 0;
   int    n_fails  = 0;
   string cur_req  = "R1";

   always #10 clk = ~clk;

   lcd_line_scan #(.LINES(LINES), .SYNC_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_data(start_data),
      .fr_in(fr_in), .cl_in(cl_in), .line_ptr(line_ptr)
   );

   // Behavioural reference: sample histories as queues, pointer as an integer.
   bit fr_hist[$];
   bit cl_hist[$];
   int m_start;
   int m_ptr;

   task automatic model_clear();
      fr_hist = {};
      cl_hist = {};
      for (int i = 0; i <= SYNC; i++) begin
         fr_hist.push_front(1'b0);
         cl_hist.push_front(1'b0);
      end
      m_start = 0;
      m_ptr   = 0;
   endtask

   initial model_clear();

   always @(posedge clk) begin
      if (!rst_n) begin
         model_clear();
      end else begin
         bit fr_edge;
         bit cl_edge;
         fr_edge = fr_hist[SYNC-1] != fr_hist[SYNC];
         cl_edge = cl_hist[SYNC-1] && !cl_hist[SYNC];
         if (fr_edge)      m_ptr = m_start;
         else if (cl_edge) m_ptr = (m_ptr + 1) % LINES;
         if (start_wr) m_start = int'(start_data);
         fr_hist.push_front(fr_in);
         cl_hist.push_front(cl_in);
         void'(fr_hist.pop_back());
         void'(cl_hist.pop_back());
      end
   end

   task automatic check(string req, int got, int exp);
      n_checks++;
      if (got != exp) begin
         n_fails++;
         $display("FAIL %s: line_ptr=%0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) check(cur_req, int'(line_ptr), m_ptr);
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_start(int v);
      @(negedge clk);
      start_wr   = 1'b1;
      start_data = LW'(v);
      @(negedge clk);
      start_wr   = 1'b0;
   endtask

   task automatic cl_pulse();
      @(negedge clk); cl_in = 1'b1;
      idle(2);        cl_in = 1'b0;
      idle(2);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(4);
      cur_req = "R1";
      check("R1", int'(line_ptr), 0);

      cur_req = "R2";
      write_start(5);
      idle(5);
      check("R2", int'(line_ptr), 0);

      cur_req = "R3";
      @(negedge clk); fr_in = 1'b1;
      idle(SYNC);
      check("R3", int'(line_ptr), 0);
      idle(1);
      check("R3", int'(line_ptr), 5);

      cur_req = "R5";
      for (int i = 0; i < 3; i++) cl_pulse();
      check("R5", int'(line_ptr), 8);

      cur_req = "R8";
      idle(10);
      check("R8", int'(line_ptr), 8);

      cur_req = "R4";
      write_start(29);
      check("R2", int'(line_ptr), 8);
      @(negedge clk); fr_in = 1'b0;
      idle(SYNC + 2);
      check("R4", int'(line_ptr), 29);

      cur_req = "R6";
      cl_pulse();
      cl_pulse();
      check("R6", int'(line_ptr), 31);
      cl_pulse();
      check("R6", int'(line_ptr), 0);
      cl_pulse();
      check("R6", int'(line_ptr), 1);

      cur_req = "R7";
      write_start(12);
      for (int i = 0; i < 2; i++) cl_pulse();
      check("R5", int'(line_ptr), 3);
      @(negedge clk);
      fr_in = 1'b1;
      cl_in = 1'b1;
      idle(SYNC + 2);
      check("R7", int'(line_ptr), 12);
      cl_in = 1'b0;
      idle(4);
      check("R5", int'(line_ptr), 12);

      cur_req = "R3";
      write_start(20);
      cl_pulse();
      @(negedge clk); fr_in = 1'b0;
      idle(SYNC + 2);
      check("R4", int'(line_ptr), 20);
      @(negedge clk); fr_in = 1'b1;
      idle(SYNC + 2);
      check("R3", int'(line_ptr), 20);

      idle(4);
      finish_run();
   end
endmodule